// File: doc/BRIEF.md
# Programmable external memory strobe sequencer

This block runs one asynchronous access to a parallel memory at a time. When a request is accepted it starts a tick counter and places every control strobe edge (chip select, address valid, write enable, output enable) at a tick count set by timing inputs. A tick is one functional clock, or two, three or four clocks when the tick divider is set. Chip select and address valid each have separate release ticks for reads and for writes. Write enable only pulses on writes and output enable only pulses on reads. Each direction also has its own cycle length.

On a read, the data bus is sampled at the programmed access tick and held on `rdata`. The cycle ends when the counter reaches the cycle length for its direction. At that point `done` pulses for one clock, all strobes return high, and `busy` drops so that the next request can be accepted. In multiplexed mode the low address bits are driven on the shared bus until the data tick. After that tick, write data is driven on writes and the bus is released on reads.

The timing inputs are read live during a cycle and must be held stable while `busy` is high. The request direction, address and write data are latched when the request is accepted.

Top module: `strobe_seq`

## Requirements
- R1: After reset, `cs_n`, `adv_n`, `we_n` and `oe_n` are 1, and `busy`, `done` and `bus_oe` are 0.
- R2: A request (`req`=1) is accepted at a rising edge where `busy` is 0. `busy` is 1 from that edge until the cycle ends. A request, direction, address or write data applied while `busy` is 1 does not affect the running cycle. If `req` is still 1 after the end, it is accepted on the next edge.
- R3: With `tick_div` = d (0..3), the tick count advances every d+1 clocks. An edge programmed for tick N changes at rising edge N*(d+1) after the acceptance edge, where edge 0 is the acceptance edge.
- R4: `cs_n` is 0 exactly while the tick is at least `cs_on_t` and below the release tick: `cs_rd_off_t` on reads (`req_wr`=0), `cs_wr_off_t` on writes (`req_wr`=1).
- R5: `adv_n` is 0 exactly while the tick is at least `adv_on_t` and below `adv_rd_off_t` (reads) or `adv_wr_off_t` (writes).
- R6: `we_n` pulses low in the window [`we_on_t`, `we_off_t`) only on writes. `oe_n` pulses low in [`oe_on_t`, `oe_off_t`) only on reads. `we_n` and `oe_n` are never low together.
- R7: A strobe whose assert tick is not less than its release tick stays 1 for the whole cycle.
- R8: The cycle length is `rd_cycle_t` ticks for reads and `wr_cycle_t` ticks for writes. A cycle of length L≥1 ends at edge L*(d+1), and a cycle of length 0 ends at edge 1. At the end edge, `done` goes to 1 for one clock, `busy` goes to 0 and all strobes return to 1. A strobe release later than the cycle end is cut off at the end.
- R9: On a read, `rdata` takes the value on `bus_in` at the edge where the tick first reaches `access_t` (the acceptance edge if `access_t` is 0). If `access_t` exceeds the read cycle length, `rdata` keeps its previous value.
- R10: With `mux_mode`=0, a write drives `req_wdata` on `bus_out` with `bus_oe`=1 for the whole cycle. A read leaves `bus_oe`=0. `mem_addr` shows the latched address from the edge after acceptance.
- R11: With `mux_mode`=1, while the tick is below `data_on_bus_t`, `bus_out` carries the low DATA_W address bits with `bus_oe`=1. From that tick onward a write drives `req_wdata` and a read releases the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request |
| req_wr | input | 1 | Direction of request, 1 = write |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| tick_div | input | 2 | Tick divider code, d selects divide by d+1 |
| mux_mode | input | 1 | Address and data share the bus |
| cs_on_t | input | TICK_W | Chip select assert tick |
| cs_rd_off_t | input | TICK_W | Chip select release tick, reads |
| cs_wr_off_t | input | TICK_W | Chip select release tick, writes |
| adv_on_t | input | TICK_W | Address valid assert tick |
| adv_rd_off_t | input | TICK_W | Address valid release tick, reads |
| adv_wr_off_t | input | TICK_W | Address valid release tick, writes |
| we_on_t | input | TICK_W | Write enable assert tick |
| we_off_t | input | TICK_W | Write enable release tick |
| oe_on_t | input | TICK_W | Output enable assert tick |
| oe_off_t | input | TICK_W | Output enable release tick |
| access_t | input | TICK_W | Read data sample tick |
| rd_cycle_t | input | TICK_W | Read cycle length in ticks |
| wr_cycle_t | input | TICK_W | Write cycle length in ticks |
| data_on_bus_t | input | TICK_W | Tick where write data replaces the address in multiplexed mode |
| bus_in | input | DATA_W | Data bus as seen from the memory |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | DATA_W | Captured read data |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W | Latched access address |
| bus_out | output | DATA_W | Value driven on the data bus |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with its defaults: TICK_W=5, ADDR_W=24 and DATA_W=16. A five-bit tick lets a release tick lie beyond the cycle length, which exercises the cut-off at the cycle end. DATA_W narrower than ADDR_W shows that only the low address bits go on the shared bus. All four divider codes are used, so edges at N, 2N, 3N and 4N clocks are each observed. An access tick past the cycle end and a zero-length cycle are both reachable inside that tick range.

// File: rtl/strobe_seq_pkg.sv
// Shared definitions for the strobe sequencer: strobe indices used to
// address the per-strobe window generators.
// Assumes nothing beyond a single clock domain.
package strobe_seq_pkg;

    typedef enum logic [1:0] {
        STB_CS  = 2'd0,
        STB_ADV = 2'd1,
        STB_WE  = 2'd2,
        STB_OE  = 2'd3
    } stb_idx_e;

    localparam int NUM_STB = 4;

endpackage

// File: rtl/strobe_tick_gen.sv
// Tick generator: accepts a request when idle, divides the clock into
// ticks, counts ticks from the acceptance edge and ends the cycle at the
// programmed length for the latched direction.
// Assumes the divider code and cycle lengths are stable while running.
module strobe_tick_gen #(
    parameter int TICK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [1:0]        tick_div,
    input  logic [TICK_W-1:0] rd_len,
    input  logic [TICK_W-1:0] wr_len,
    output logic              accept,
    output logic              step,
    output logic              run_q,
    output logic              run_nxt,
    output logic              wr_q,
    output logic              wr_nxt,
    output logic [TICK_W-1:0] tick_nxt,
    output logic              done
);

    logic [1:0]        pre_q;
    logic [TICK_W-1:0] tick_q;
    logic [TICK_W-1:0] len;
    logic              end_now;

    // next-state decode of acceptance, tick advance and cycle end
    always_comb begin
        accept   = req && !run_q;
        step     = run_q && (pre_q >= tick_div);
        wr_nxt   = accept ? req_wr : wr_q;
        len      = wr_q ? wr_len : rd_len;
        if (accept)
            tick_nxt = '0;
        else if (step)
            tick_nxt = tick_q + TICK_W'(1);
        else
            tick_nxt = tick_q;
        end_now  = run_q && (tick_nxt >= len);
        run_nxt  = accept || (run_q && !end_now);
    end

    // state registers for prescaler, tick count, direction and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
            run_q  <= 1'b0;
            wr_q   <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (accept || step || !run_q)
                pre_q <= '0;
            else
                pre_q <= pre_q + 2'd1;
            tick_q <= tick_nxt;
            run_q  <= run_nxt;
            wr_q   <= wr_nxt;
            done   <= end_now;
        end
    end

endmodule

// File: rtl/strobe_window.sv
// One strobe: registered active-low output that is low while the next
// tick lies in [on, off) of a running cycle with the strobe enabled.
// Assumes on/off are stable during the cycle; on >= off keeps it high.
module strobe_window #(
    parameter int TICK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_nxt,
    input  logic              en,
    input  logic [TICK_W-1:0] on_tick,
    input  logic [TICK_W-1:0] off_tick,
    input  logic [TICK_W-1:0] tick_nxt,
    output logic              out_n
);

    logic hit;

    // window compare on the upcoming tick
    always_comb begin
        hit = run_nxt && en && (tick_nxt >= on_tick) && (tick_nxt < off_tick);
    end

    // register the strobe so the pin never glitches
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_n <= 1'b1;
        else
            out_n <= !hit;
    end

endmodule

// File: rtl/strobe_bus_path.sv
// Data path: latches address and write data at acceptance, drives the
// shared or dedicated data bus and captures read data at the access tick.
// Assumes ADDR_W >= DATA_W; only low address bits reach the shared bus.
module strobe_bus_path #(
    parameter int TICK_W = 5,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              step,
    input  logic              run_q,
    input  logic              run_nxt,
    input  logic              wr_nxt,
    input  logic [TICK_W-1:0] tick_nxt,
    input  logic              mux_mode,
    input  logic [TICK_W-1:0] data_tick,
    input  logic [TICK_W-1:0] acc_tick,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] addr_nxt;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] wdata_nxt;
    logic              addr_phase;
    logic              cap;

    // select latched or incoming request data, decode bus phase and capture
    always_comb begin
        addr_nxt   = accept ? addr_in : mem_addr;
        wdata_nxt  = accept ? wdata_in : wdata_q;
        addr_phase = mux_mode && (tick_nxt < data_tick);
        cap        = !wr_nxt && (tick_nxt == acc_tick) && (accept || (run_q && step));
    end

    // bus drive, latched request fields and read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
            bus_out  <= '0;
            bus_oe   <= 1'b0;
            rdata    <= '0;
        end else begin
            mem_addr <= addr_nxt;
            wdata_q  <= wdata_nxt;
            bus_oe   <= run_nxt && (wr_nxt || addr_phase);
            bus_out  <= addr_phase ? addr_nxt[DATA_W-1:0] : wdata_nxt;
            if (cap)
                rdata <= bus_in;
        end
    end

endmodule

// File: rtl/strobe_seq.sv
// Top of the strobe sequencer: one asynchronous memory access per request,
// each strobe edge at a programmed tick, direction-specific release ticks
// and cycle lengths. Assumes timing inputs are held while busy is high.
module strobe_seq
    import strobe_seq_pkg::*;
#(
    parameter int TICK_W = 5,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        tick_div,
    input  logic              mux_mode,
    input  logic [TICK_W-1:0] cs_on_t,
    input  logic [TICK_W-1:0] cs_rd_off_t,
    input  logic [TICK_W-1:0] cs_wr_off_t,
    input  logic [TICK_W-1:0] adv_on_t,
    input  logic [TICK_W-1:0] adv_rd_off_t,
    input  logic [TICK_W-1:0] adv_wr_off_t,
    input  logic [TICK_W-1:0] we_on_t,
    input  logic [TICK_W-1:0] we_off_t,
    input  logic [TICK_W-1:0] oe_on_t,
    input  logic [TICK_W-1:0] oe_off_t,
    input  logic [TICK_W-1:0] access_t,
    input  logic [TICK_W-1:0] rd_cycle_t,
    input  logic [TICK_W-1:0] wr_cycle_t,
    input  logic [TICK_W-1:0] data_on_bus_t,
    input  logic [DATA_W-1:0] bus_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              cs_n,
    output logic              adv_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    logic              accept;
    logic              step;
    logic              run_q;
    logic              run_nxt;
    logic              wr_q;
    logic              wr_nxt;
    logic [TICK_W-1:0] tick_nxt;

    logic [TICK_W-1:0] on_v  [NUM_STB];
    logic [TICK_W-1:0] off_v [NUM_STB];
    logic [NUM_STB-1:0] en_v;
    logic [NUM_STB-1:0] stb_n;

    strobe_tick_gen #(.TICK_W(TICK_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .tick_div (tick_div),
        .rd_len   (rd_cycle_t),
        .wr_len   (wr_cycle_t),
        .accept   (accept),
        .step     (step),
        .run_q    (run_q),
        .run_nxt  (run_nxt),
        .wr_q     (wr_q),
        .wr_nxt   (wr_nxt),
        .tick_nxt (tick_nxt),
        .done     (done)
    );

    // per-strobe window bounds and enables, release ticks by direction
    always_comb begin
        on_v[STB_CS]   = cs_on_t;
        off_v[STB_CS]  = wr_nxt ? cs_wr_off_t : cs_rd_off_t;
        en_v[STB_CS]   = 1'b1;
        on_v[STB_ADV]  = adv_on_t;
        off_v[STB_ADV] = wr_nxt ? adv_wr_off_t : adv_rd_off_t;
        en_v[STB_ADV]  = 1'b1;
        on_v[STB_WE]   = we_on_t;
        off_v[STB_WE]  = we_off_t;
        en_v[STB_WE]   = wr_nxt;
        on_v[STB_OE]   = oe_on_t;
        off_v[STB_OE]  = oe_off_t;
        en_v[STB_OE]   = !wr_nxt;
    end

    for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
        strobe_window #(.TICK_W(TICK_W)) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_nxt  (run_nxt),
            .en       (en_v[i]),
            .on_tick  (on_v[i]),
            .off_tick (off_v[i]),
            .tick_nxt (tick_nxt),
            .out_n    (stb_n[i])
        );
    end

    strobe_bus_path #(
        .TICK_W (TICK_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .step      (step),
        .run_q     (run_q),
        .run_nxt   (run_nxt),
        .wr_nxt    (wr_nxt),
        .tick_nxt  (tick_nxt),
        .mux_mode  (mux_mode),
        .data_tick (data_on_bus_t),
        .acc_tick  (access_t),
        .addr_in   (req_addr),
        .wdata_in  (req_wdata),
        .bus_in    (bus_in),
        .mem_addr  (mem_addr),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .rdata     (rdata)
    );

    // outputs from internal state
    always_comb begin
        busy  = run_q;
        cs_n  = stb_n[STB_CS];
        adv_n = stb_n[STB_ADV];
        we_n  = stb_n[STB_WE];
        oe_n  = stb_n[STB_OE];
    end

    // direction register feeds only next-state logic inside the tick block
    logic unused_wr;
    always_comb unused_wr = wr_q;

endmodule

// File: rtl/strobe_seq_chk.sv
// Protocol checker for the strobe sequencer, bound to the top module.
// Assumes synchronous active-low reset on rst_n.
module strobe_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic adv_n,
    input logic we_n,
    input logic oe_n,
    input logic bus_oe
);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n && adv_n && we_n && oe_n));

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R6
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && adv_n && we_n && oe_n && !bus_oe));

endmodule

bind strobe_seq strobe_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .busy   (busy),
    .done   (done),
    .cs_n   (cs_n),
    .adv_n  (adv_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .bus_oe (bus_oe)
);

// File: tb/test_strobe_seq.sv
module test_strobe_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 5;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int WATCHDOG = 100000;

    typedef struct packed {
        logic          wr;
        logic [1:0]    div;
        logic          mux;
        logic [TW-1:0] cs_on, cs_rd, cs_wr;
        logic [TW-1:0] adv_on, adv_rd, adv_wr;
        logic [TW-1:0] we_on, we_off, oe_on, oe_off;
        logic [TW-1:0] acc, rdc, wrc, wdon;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 5'd0, 5'd6, 5'd8, 5'd0, 5'd2, 5'd3, 5'd1, 5'd4, 5'd2, 5'd6, 5'd5, 5'd7, 5'd9, 5'd3},
        '{1'b1, 2'd0, 1'b0, 5'd0, 5'd6, 5'd8, 5'd0, 5'd2, 5'd3, 5'd1, 5'd4, 5'd2, 5'd6, 5'd5, 5'd7, 5'd9, 5'd3},
        '{1'b0, 2'd1, 1'b1, 5'd1, 5'd5, 5'd7, 5'd0, 5'd1, 5'd2, 5'd2, 5'd4, 5'd2, 5'd5, 5'd4, 5'd6, 5'd8, 5'd2},
        '{1'b1, 2'd3, 1'b1, 5'd1, 5'd5, 5'd7, 5'd0, 5'd1, 5'd2, 5'd2, 5'd4, 5'd2, 5'd5, 5'd4, 5'd6, 5'd8, 5'd2},
        '{1'b0, 2'd2, 1'b0, 5'd0, 5'd3, 5'd9, 5'd1, 5'd2, 5'd2, 5'd0, 5'd9, 5'd1, 5'd3, 5'd3, 5'd4, 5'd10, 5'd0},
        '{1'b0, 2'd0, 1'b0, 5'd4, 5'd2, 5'd2, 5'd3, 5'd3, 5'd1, 5'd0, 5'd5, 5'd3, 5'd3, 5'd8, 5'd6, 5'd6, 5'd0},
        '{1'b0, 2'd1, 1'b0, 5'd0, 5'd4, 5'd4, 5'd0, 5'd4, 5'd4, 5'd0, 5'd1, 5'd0, 5'd2, 5'd0, 5'd0, 5'd3, 5'd0},
        '{1'b1, 2'd0, 1'b1, 5'd2, 5'd1, 5'd30, 5'd0, 5'd1, 5'd2, 5'd1, 5'd20, 5'd0, 5'd9, 5'd0, 5'd2, 5'd5, 5'd31},
        '{1'b1, 2'd2, 1'b1, 5'd0, 5'd1, 5'd3, 5'd0, 5'd0, 5'd1, 5'd1, 5'd3, 5'd0, 5'd4, 5'd1, 5'd2, 5'd4, 5'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    tick_div = '0;
    logic          mux_mode = 1'b0;
    logic [TW-1:0] cs_on_t = '0, cs_rd_off_t = '0, cs_wr_off_t = '0;
    logic [TW-1:0] adv_on_t = '0, adv_rd_off_t = '0, adv_wr_off_t = '0;
    logic [TW-1:0] we_on_t = '0, we_off_t = '0, oe_on_t = '0, oe_off_t = '0;
    logic [TW-1:0] access_t = '0, rd_cycle_t = '0, wr_cycle_t = '0, data_on_bus_t = '0;
    logic [DW-1:0] bus_in = '0;
    logic          busy, done, cs_n, adv_n, we_n, oe_n, bus_oe;
    logic [DW-1:0] rdata, bus_out;
    logic [AW-1:0] mem_addr;

    int n_total = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_seq #(.TICK_W(TW), .ADDR_W(AW), .DATA_W(DW)) i_strobe_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .tick_div(tick_div),
        .mux_mode(mux_mode), .cs_on_t(cs_on_t), .cs_rd_off_t(cs_rd_off_t),
        .cs_wr_off_t(cs_wr_off_t), .adv_on_t(adv_on_t), .adv_rd_off_t(adv_rd_off_t),
        .adv_wr_off_t(adv_wr_off_t), .we_on_t(we_on_t), .we_off_t(we_off_t),
        .oe_on_t(oe_on_t), .oe_off_t(oe_off_t), .access_t(access_t),
        .rd_cycle_t(rd_cycle_t), .wr_cycle_t(wr_cycle_t),
        .data_on_bus_t(data_on_bus_t), .bus_in(bus_in), .busy(busy),
        .done(done), .rdata(rdata), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .mem_addr(mem_addr), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic bit in_win(input int on, input int off, input int t);
        return (on <= t) && (t < off);
    endfunction

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    task automatic load_cfg(input vec_t v);
        tick_div = v.div; mux_mode = v.mux;
        cs_on_t = v.cs_on; cs_rd_off_t = v.cs_rd; cs_wr_off_t = v.cs_wr;
        adv_on_t = v.adv_on; adv_rd_off_t = v.adv_rd; adv_wr_off_t = v.adv_wr;
        we_on_t = v.we_on; we_off_t = v.we_off; oe_on_t = v.oe_on; oe_off_t = v.oe_off;
        access_t = v.acc; rd_cycle_t = v.rdc; wr_cycle_t = v.wrc; data_on_bus_t = v.wdon;
    endtask

    // one full access against the requirement model; called at a negedge
    task automatic run_vec(input vec_t v, input int id);
        int d, len, end_e, t;
        bit run, aph, exp_oe;
        string ex;
        logic [DW-1:0] base;
        logic [AW-1:0] a;
        logic [DW-1:0] w;
        d = int'(v.div) + 1;
        len = v.wr ? int'(v.wrc) : int'(v.rdc);
        end_e = (len == 0) ? 1 : len * d;
        ex = (d > 1) ? " R3" : "";
        base = 16'h4000 + DW'(id * 256);
        a = 24'h3C1000 + AW'(id * 24'h010203);
        w = 16'hC000 + DW'(id);
        load_cfg(v);
        req_wr = v.wr; req_addr = a; req_wdata = w;
        bus_in = base;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k <= end_e + 1; k++) begin
            t = k / d;
            run = (k < end_e);
            chk(cs_n == !(run && in_win(v.cs_on, v.wr ? v.cs_wr : v.cs_rd, t)),
                (v.cs_on >= (v.wr ? v.cs_wr : v.cs_rd)) ? "R7" : "R4",
                $sformatf("cs_n vec%0d k%0d%s", id, k, ex), cs_n, !cs_n);
            chk(adv_n == !(run && in_win(v.adv_on, v.wr ? v.adv_wr : v.adv_rd, t)),
                (v.adv_on >= (v.wr ? v.adv_wr : v.adv_rd)) ? "R7" : "R5",
                $sformatf("adv_n vec%0d k%0d%s", id, k, ex), adv_n, !adv_n);
            chk(we_n == !(run && v.wr && in_win(v.we_on, v.we_off, t)), "R6",
                $sformatf("we_n vec%0d k%0d%s", id, k, ex), we_n, !we_n);
            chk(oe_n == !(run && !v.wr && in_win(v.oe_on, v.oe_off, t)), "R6",
                $sformatf("oe_n vec%0d k%0d%s", id, k, ex), oe_n, !oe_n);
            chk(busy == run, "R2", $sformatf("busy vec%0d k%0d", id, k), busy, run);
            chk(done == (k == end_e), "R8", $sformatf("done vec%0d k%0d", id, k),
                done, (k == end_e));
            aph = v.mux && (t < int'(v.wdon));
            exp_oe = run && (v.wr || aph);
            chk(bus_oe == exp_oe, v.mux ? "R11" : "R10",
                $sformatf("bus_oe vec%0d k%0d", id, k), bus_oe, exp_oe);
            if (exp_oe)
                chk(bus_out == (aph ? a[DW-1:0] : w), v.mux ? "R11" : "R10",
                    $sformatf("bus_out vec%0d k%0d", id, k), bus_out, aph ? a[DW-1:0] : w);
            if (k == 0)
                chk(mem_addr == a, "R10", $sformatf("mem_addr vec%0d", id), mem_addr, a);
            if (k == end_e) begin
                if (!v.wr && (int'(v.acc) * d <= end_e))
                    exp_rd = base + DW'(int'(v.acc) * d);
                chk(rdata == exp_rd, "R9", $sformatf("rdata vec%0d", id), rdata, exp_rd);
            end
            bus_in = base + DW'(k + 1);
            @(negedge clk);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            n_bad++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_up();
        end
    end

    initial begin
        int end_e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n && adv_n && we_n && oe_n, "R1", "strobes after reset",
            {cs_n, adv_n, we_n, oe_n}, 4'hF);
        chk(!busy && !done && !bus_oe, "R1", "busy/done/bus_oe after reset",
            {busy, done, bus_oe}, 3'b000);

        // table walk: R3..R11 across directions, dividers and modes
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R2: request held high and changed during a read cycle is ignored
        load_cfg(VECS[0]);
        req_wr = 1'b0; req_addr = 24'h123456; req_wdata = 16'h0BAD;
        req = 1'b1;
        @(negedge clk);
        req_wr = 1'b1; req_addr = 24'h654321;
        end_e = int'(VECS[0].rdc);
        for (int k = 0; k <= end_e + 1; k++) begin
            if (k < end_e) begin
                chk(we_n == 1'b1, "R2", $sformatf("held req direction k%0d", k), we_n, 1);
                chk(mem_addr == 24'h123456, "R2", $sformatf("held req addr k%0d", k),
                    mem_addr, 24'h123456);
                chk(busy == 1'b1, "R2", $sformatf("busy held k%0d", k), busy, 1);
            end
            if (k == end_e)
                chk(done && !busy, "R2", "first cycle ends", {done, busy}, 2'b10);
            if (k == end_e + 1) begin
                chk(busy == 1'b1, "R2", "pending req accepted after end", busy, 1);
                chk(mem_addr == 24'h654321, "R2", "second cycle addr", mem_addr, 24'h654321);
            end
            @(negedge clk);
        end
        req = 1'b0;
        for (int k = 0; k < 64 && busy; k++) @(negedge clk);
        chk(!busy, "R8", "second cycle ended", busy, 0);
        finish_up();
    end

endmodule